// File: doc/BRIEF.md
# Mode-Banked Register File

This block is the integer register file of a small 32-bit RISC core. Software always names sixteen logical registers with a 4-bit number, but the physical storage behind logical registers 8 to 14 depends on the processor mode presented on a 5-bit mode input. When an exception mode is entered, some registers are swapped for private copies. The interrupted context therefore survives without being stored to memory. The fast-interrupt mode swaps seven registers (8 to 14). The interrupt, supervisor, abort and undefined modes each swap only registers 13 (stack pointer) and 14. System mode works on the user copies. In total there are thirty 32-bit general-purpose registers.

Two combinational read ports and one clocked write port serve the core. Logical register 15 is the program counter, which advances by four on request or is loaded by a write to index 15. The block also holds the current status register and five saved status registers, one per exception mode. The saved status register is reached through its own port and selected by the current mode. Instruction decode, exception sequencing and the ALU sit outside this block.

Top module: `bankreg_file`

## Requirements
- R1: A synchronous reset (rst_n low at a rising edge) clears every general-purpose register, every saved status register and the PC to zero, and sets the current status register to 32'h0000_0013.
- R2: Logical registers 0 to 7 are one physical set shared by all modes, and registers 8 to 12 are shared by every mode except fast-interrupt.
- R3: In fast-interrupt mode (code 5'b10001), logical registers 8 to 14 map to a private set, and writes there leave the user copies unchanged.
- R4: Interrupt (5'b10010), supervisor (5'b10011), abort (5'b10111) and undefined (5'b11011) modes each have a private pair for logical registers 13 and 14.
- R5: User (5'b10000), system (5'b11111) and every unlisted mode code all use the user set of registers 0 to 14.
- R6: A write of wr_data to logical register wr_idx (0 to 14) with wr_en high takes effect at the rising edge. A read of that register in the same cycle returns the old value.
- R7: The two read ports are independent, and each returns the register selected by its own index in the current mode.
- R8: Reading index 15 returns the PC. A write to index 15 loads the PC and takes priority over pc_inc. Otherwise pc_inc high adds 4 to the PC at each edge.
- R9: Each exception mode has its own saved status register, accessed through sr_saved_o and sr_saved_we. In user, system or an unlisted mode the port reads zero and writes change no saved register.
- R10: sr_cur_we high loads sr_wdata into the current status register at the rising edge. sr_cur_o shows it in every mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 5 | Current processor mode code |
| rd_a_idx | input | 4 | Logical index for read port A |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Logical index for read port B |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Logical index to write |
| wr_data | input | 32 | Write data |
| pc_inc | input | 1 | Advance PC by 4 |
| sr_wdata | input | 32 | Write data for status registers |
| sr_cur_we | input | 1 | Write current status register |
| sr_cur_o | output | 32 | Current status register |
| sr_saved_we | input | 1 | Write saved status register of the current mode |
| sr_saved_o | output | 32 | Saved status register of the current mode |

## Verification
The hardest case to reach is proof of isolation between banks. A value written in one mode must be seen, or not seen, from another mode. The same logical index must also hold distinct contents in several modes at once, and none of this is visible from any single cycle at the ports. The stimulus table seeds the same logical registers with different values under user, fast-interrupt and the two-register exception modes. It then switches modes and reads those indices back, including through system mode and an unlisted mode code that must fall back to the user copies. Directed tests cover same-cycle write-then-read, PC load against increment, and saved status writes attempted from user mode.

// File: rtl/bankreg_pkg.sv
// Shared mode codes and bank type for the mode-banked register file.
// Assumes the 5-bit mode encoding given in the brief.
package bankreg_pkg;
    localparam logic [4:0] MODE_USR = 5'b10000;
    localparam logic [4:0] MODE_FIQ = 5'b10001;
    localparam logic [4:0] MODE_IRQ = 5'b10010;
    localparam logic [4:0] MODE_SVC = 5'b10011;
    localparam logic [4:0] MODE_ABT = 5'b10111;
    localparam logic [4:0] MODE_UND = 5'b11011;
    localparam logic [4:0] MODE_SYS = 5'b11111;

    // Bank selector: BK_USR covers user, system and unlisted codes.
    typedef enum logic [2:0] {
        BK_USR = 3'd0,
        BK_FIQ = 3'd1,
        BK_IRQ = 3'd2,
        BK_SVC = 3'd3,
        BK_ABT = 3'd4,
        BK_UND = 3'd5
    } bank_e;

    localparam int NUM_EXC_BANKS = 5;
endpackage

// File: rtl/bankreg_mode_dec.sv
// Turns the raw mode code into a bank selector.
// Assumes any code not listed as an exception mode behaves as user mode.
module bankreg_mode_dec
    import bankreg_pkg::*;
(
    input  logic [4:0] mode_i,
    output bank_e      bank_o
);
    // Code-to-bank lookup with user fallback.
    always_comb begin
        case (mode_i)
            MODE_FIQ: bank_o = BK_FIQ;
            MODE_IRQ: bank_o = BK_IRQ;
            MODE_SVC: bank_o = BK_SVC;
            MODE_ABT: bank_o = BK_ABT;
            MODE_UND: bank_o = BK_UND;
            default:  bank_o = BK_USR;
        endcase
    end
endmodule

// File: rtl/bankreg_map.sv
// Maps a logical register index (0..14) in a given bank to a physical slot.
// Layout: 0..14 user set, then the fast-interrupt set for FIQ_FIRST..14,
// then one pair (13,14) for each remaining exception bank in enum order.
// Index 15 is the PC and yields slot 0; callers must not use it.
module bankreg_map
    import bankreg_pkg::*;
#(
    parameter int FIQ_FIRST = 8,
    parameter int PHYS_W    = 5
) (
    input  bank_e             bank_i,
    input  logic [3:0]        idx_i,
    output logic [PHYS_W-1:0] phys_o
);
    localparam int FIQ_BASE  = 15;
    localparam int PAIR_BASE = FIQ_BASE + (15 - FIQ_FIRST);

    // Select shared slot, fast-interrupt slot or exception pair slot.
    always_comb begin
        phys_o = PHYS_W'(idx_i);
        if (idx_i == 4'd15) begin
            phys_o = '0;
        end else if (bank_i == BK_FIQ && int'(idx_i) >= FIQ_FIRST) begin
            phys_o = PHYS_W'(FIQ_BASE + int'(idx_i) - FIQ_FIRST);
        end else if (bank_i != BK_USR && bank_i != BK_FIQ && idx_i >= 4'd13) begin
            phys_o = PHYS_W'(PAIR_BASE + 2 * (int'(bank_i) - 2) + int'(idx_i) - 13);
        end
    end
endmodule

// File: rtl/bankreg_sr.sv
// Current status register plus one saved status register per exception
// bank. Assumes the bank selector is already decoded from the mode code.
module bankreg_sr
    import bankreg_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bank_e             bank_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              cur_we_i,
    input  logic              saved_we_i,
    output logic [DATA_W-1:0] cur_o,
    output logic [DATA_W-1:0] saved_o
);
    localparam logic [DATA_W-1:0] CUR_RST = DATA_W'({3'b000, MODE_SVC});

    logic [DATA_W-1:0] cur_q;
    logic [DATA_W-1:0] saved_q [NUM_EXC_BANKS];

    // Current status register update.
    always_ff @(posedge clk) begin
        if (!rst_n)        cur_q <= CUR_RST;
        else if (cur_we_i) cur_q <= wdata_i;
    end

    // One saved register per exception bank, written only in that bank.
    for (genvar g = 0; g < NUM_EXC_BANKS; g++) begin : g_saved
        always_ff @(posedge clk) begin
            if (!rst_n)
                saved_q[g] <= '0;
            else if (saved_we_i && int'(bank_i) == g + 1)
                saved_q[g] <= wdata_i;
        end
    end

    // Saved register read, zero in the user bank.
    always_comb begin
        saved_o = '0;
        if (bank_i != BK_USR) saved_o = saved_q[int'(bank_i) - 1];
    end

    assign cur_o = cur_q;
endmodule

// File: rtl/bankreg_file.sv
// Top of the mode-banked register file: two combinational read ports, one
// write port, PC at logical index 15, and status registers.
// Assumes mode_i is stable around the clock edge along with the write inputs.
module bankreg_file
    import bankreg_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int FIQ_FIRST = 8,
    parameter int PC_STEP   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        mode_i,
    input  logic [3:0]        rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [3:0]        rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [3:0]        wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              pc_inc,
    input  logic [DATA_W-1:0] sr_wdata,
    input  logic              sr_cur_we,
    output logic [DATA_W-1:0] sr_cur_o,
    input  logic              sr_saved_we,
    output logic [DATA_W-1:0] sr_saved_o
);
    localparam int NUM_PHYS = 15 + (15 - FIQ_FIRST) + 2 * (NUM_EXC_BANKS - 1);
    localparam int PHYS_W   = $clog2(NUM_PHYS);
    localparam int NUM_PORT = 3;

    bank_e             bank;
    logic [3:0]        port_idx  [NUM_PORT];
    logic [PHYS_W-1:0] port_phys [NUM_PORT];
    logic [DATA_W-1:0] gpr_q     [NUM_PHYS];
    logic [DATA_W-1:0] pc_q;
    logic              gpr_we;
    logic              pc_we;

    bankreg_mode_dec u_dec (
        .mode_i (mode_i),
        .bank_o (bank)
    );

    assign port_idx[0] = rd_a_idx;
    assign port_idx[1] = rd_b_idx;
    assign port_idx[2] = wr_idx;

    // One mapper per port: read A, read B, write.
    for (genvar p = 0; p < NUM_PORT; p++) begin : g_map
        bankreg_map #(
            .FIQ_FIRST (FIQ_FIRST),
            .PHYS_W    (PHYS_W)
        ) u_map (
            .bank_i (bank),
            .idx_i  (port_idx[p]),
            .phys_o (port_phys[p])
        );
    end

    assign pc_we  = wr_en && (wr_idx == 4'd15);
    assign gpr_we = wr_en && (wr_idx != 4'd15);

    // Physical register storage, one slot per generate iteration.
    for (genvar s = 0; s < NUM_PHYS; s++) begin : g_gpr
        always_ff @(posedge clk) begin
            if (!rst_n)
                gpr_q[s] <= '0;
            else if (gpr_we && int'(port_phys[2]) == s)
                gpr_q[s] <= wr_data;
        end
    end

    // PC: explicit load beats increment.
    always_ff @(posedge clk) begin
        if (!rst_n)      pc_q <= '0;
        else if (pc_we)  pc_q <= wr_data;
        else if (pc_inc) pc_q <= pc_q + DATA_W'(PC_STEP);
    end

    // Read muxes, PC at index 15.
    always_comb begin
        rd_a_data = (rd_a_idx == 4'd15) ? pc_q : gpr_q[port_phys[0]];
        rd_b_data = (rd_b_idx == 4'd15) ? pc_q : gpr_q[port_phys[1]];
    end

    bankreg_sr #(
        .DATA_W (DATA_W)
    ) u_sr (
        .clk        (clk),
        .rst_n      (rst_n),
        .bank_i     (bank),
        .wdata_i    (sr_wdata),
        .cur_we_i   (sr_cur_we),
        .saved_we_i (sr_saved_we),
        .cur_o      (sr_cur_o),
        .saved_o    (sr_saved_o)
    );
endmodule

// File: rtl/bankreg_file_chk.sv
// Property checker for bankreg_file, bound to every instance of it.
// Assumes the default 32-bit width and a PC step of 4.
module bankreg_file_chk
    import bankreg_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic [4:0]  mode_i,
    input logic [3:0]  rd_a_idx,
    input logic [31:0] rd_a_data,
    input logic        wr_en,
    input logic [3:0]  wr_idx,
    input logic [31:0] wr_data,
    input logic        pc_inc,
    input logic [31:0] sr_wdata,
    input logic        sr_cur_we,
    input logic [31:0] sr_cur_o,
    input logic [31:0] sr_saved_o,
    input logic [31:0] pc_q
);
    logic exc_mode;
    assign exc_mode = (mode_i == MODE_FIQ) || (mode_i == MODE_IRQ) ||
                      (mode_i == MODE_SVC) || (mode_i == MODE_ABT) ||
                      (mode_i == MODE_UND);

    // R1: first cycle out of reset shows the reset state.
    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pc_q == 32'd0 && sr_cur_o == 32'h13));

    // R6: written register reads back the next cycle in the same mode.
    p_wr_then_rd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en) && $past(wr_idx) != 4'd15 &&
         rd_a_idx == $past(wr_idx) && mode_i == $past(mode_i))
        |-> rd_a_data == $past(wr_data));

    // R8: increment without load adds 4.
    p_pc_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_inc && !(wr_en && wr_idx == 4'd15)) |=> pc_q == $past(pc_q) + 32'd4);

    // R8: load through index 15 wins over increment.
    p_pc_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == 4'd15) |=> pc_q == $past(wr_data));

    // R9: saved status port reads zero outside exception modes.
    p_saved_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_mode |-> sr_saved_o == 32'd0);

    // R10: current status register loads on its write enable.
    p_sr_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sr_cur_we |=> sr_cur_o == $past(sr_wdata));
endmodule

bind bankreg_file bankreg_file_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (mode_i),
    .rd_a_idx   (rd_a_idx),
    .rd_a_data  (rd_a_data),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data),
    .pc_inc     (pc_inc),
    .sr_wdata   (sr_wdata),
    .sr_cur_we  (sr_cur_we),
    .sr_cur_o   (sr_cur_o),
    .sr_saved_o (sr_saved_o),
    .pc_q       (pc_q)
);

// File: tb/bankreg_file_bench.sv
// Self-checking bench: a vector table of write-then-read steps across
// modes, then directed tests for PC, status registers and reset.
module bankreg_file_bench;
    localparam logic [4:0] USR = 5'b10000, FIQ = 5'b10001, IRQ = 5'b10010,
                           SVC = 5'b10011, ABT = 5'b10111, UND = 5'b11011,
                           SYS = 5'b11111, BAD = 5'b10101;

    typedef struct packed {
        logic [4:0]  mode;
        logic        wen;
        logic [3:0]  widx;
        logic [31:0] wdata;
        logic [3:0]  ridx;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{USR, 1'b1, 4'd8,  32'h11,   4'd8,  32'h11},   // R2
        '{FIQ, 1'b1, 4'd8,  32'h22,   4'd8,  32'h22},   // R3
        '{USR, 1'b0, 4'd0,  32'h0,    4'd8,  32'h11},   // R3 user copy kept
        '{USR, 1'b1, 4'd13, 32'h1300, 4'd13, 32'h1300}, // R5
        '{SYS, 1'b0, 4'd0,  32'h0,    4'd13, 32'h1300}, // R5 system shares
        '{SVC, 1'b1, 4'd13, 32'h5D,   4'd13, 32'h5D},   // R4
        '{ABT, 1'b1, 4'd14, 32'hAB,   4'd14, 32'hAB},   // R4
        '{ABT, 1'b0, 4'd0,  32'h0,    4'd13, 32'h0},    // R4 abort SP private
        '{UND, 1'b1, 4'd3,  32'h33,   4'd3,  32'h33},   // R2
        '{IRQ, 1'b0, 4'd0,  32'h0,    4'd3,  32'h33},   // R2 shared low
        '{USR, 1'b1, 4'd12, 32'hC,    4'd12, 32'hC},    // R2
        '{FIQ, 1'b0, 4'd0,  32'h0,    4'd12, 32'h0},    // R3 banked r12
        '{IRQ, 1'b0, 4'd0,  32'h0,    4'd12, 32'hC},    // R2 r12 shared
        '{BAD, 1'b0, 4'd0,  32'h0,    4'd13, 32'h1300}, // R5 unlisted code
        '{SVC, 1'b0, 4'd0,  32'h0,    4'd14, 32'h0},    // R4
        '{IRQ, 1'b0, 4'd0,  32'h0,    4'd13, 32'h0}     // R4
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  mode_i = USR;
    logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [31:0] rd_a_data, rd_b_data, wr_data = '0, sr_wdata = '0;
    logic [31:0] sr_cur_o, sr_saved_o;
    logic        wr_en = 1'b0, pc_inc = 1'b0, sr_cur_we = 1'b0, sr_saved_we = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bankreg_file u_bankreg_file (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (mode_i),
        .rd_a_idx    (rd_a_idx),
        .rd_a_data   (rd_a_data),
        .rd_b_idx    (rd_b_idx),
        .rd_b_data   (rd_b_data),
        .wr_en       (wr_en),
        .wr_idx      (wr_idx),
        .wr_data     (wr_data),
        .pc_inc      (pc_inc),
        .sr_wdata    (sr_wdata),
        .sr_cur_we   (sr_cur_we),
        .sr_cur_o    (sr_cur_o),
        .sr_saved_we (sr_saved_we),
        .sr_saved_o  (sr_saved_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive at negedge, let one rising edge pass, drop the strobes.
    task automatic tick();
        @(posedge clk);
        #1;
        wr_en = 1'b0; pc_inc = 1'b0; sr_cur_we = 1'b0; sr_saved_we = 1'b0;
        #1;
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        tick();
        rst_n = 1'b1;
        // R1 reset state.
        rd_a_idx = 4'd15; rd_b_idx = 4'd9; #1;
        check("R1 pc", rd_a_data, 32'h0);
        check("R1 r9", rd_b_data, 32'h0);
        check("R1 cur sr", sr_cur_o, 32'h13);
        mode_i = SVC; #1;
        check("R1 saved sr", sr_saved_o, 32'h0);

        // Vector table walk: write step then read on both ports.
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            mode_i = VEC[i].mode; wr_en = VEC[i].wen;
            wr_idx = VEC[i].widx; wr_data = VEC[i].wdata;
            tick();
            rd_a_idx = VEC[i].ridx; rd_b_idx = VEC[i].ridx; #1;
            check($sformatf("R6 vec%0d port A", i), rd_a_data, VEC[i].exp);
            check($sformatf("R7 vec%0d port B", i), rd_b_data, VEC[i].exp);
        end

        // R6: same-cycle read returns old value; R7 ports differ.
        @(negedge clk);
        mode_i = USR; wr_en = 1'b1; wr_idx = 4'd8; wr_data = 32'h99;
        rd_a_idx = 4'd8; rd_b_idx = 4'd13; #1;
        check("R6 old value before edge", rd_a_data, 32'h11);
        check("R7 port B other reg", rd_b_data, 32'h1300);
        tick();
        check("R6 new value after edge", rd_a_data, 32'h99);

        // R8: PC increment, load priority.
        @(negedge clk);
        rd_a_idx = 4'd15;
        pc_inc = 1'b1; tick();
        pc_inc = 1'b1; tick();
        pc_inc = 1'b1; tick();
        check("R8 pc after 3 inc", rd_a_data, 32'd12);
        @(negedge clk);
        pc_inc = 1'b1; wr_en = 1'b1; wr_idx = 4'd15; wr_data = 32'h100;
        tick();
        check("R8 load beats inc", rd_a_data, 32'h100);
        @(negedge clk);
        pc_inc = 1'b1; tick();
        check("R8 inc after load", rd_a_data, 32'h104);
        rd_b_idx = 4'd15; #1;
        check("R8 pc on port B", rd_b_data, 32'h104);

        // R9: saved status per exception bank; user writes ignored.
        @(negedge clk);
        mode_i = SVC; sr_saved_we = 1'b1; sr_wdata = 32'hA5; tick();
        check("R9 svc saved", sr_saved_o, 32'hA5);
        mode_i = ABT; #1;
        check("R9 abt saved separate", sr_saved_o, 32'h0);
        @(negedge clk);
        mode_i = USR; sr_saved_we = 1'b1; sr_wdata = 32'h77; tick();
        check("R9 user reads zero", sr_saved_o, 32'h0);
        mode_i = SVC; #1;
        check("R9 user write ignored svc", sr_saved_o, 32'hA5);
        mode_i = ABT; #1;
        check("R9 user write ignored abt", sr_saved_o, 32'h0);
        mode_i = SYS; #1;
        check("R9 system reads zero", sr_saved_o, 32'h0);

        // R10: current status register write, visible in any mode.
        @(negedge clk);
        sr_cur_we = 1'b1; sr_wdata = 32'hF0000010; tick();
        check("R10 cur sr write", sr_cur_o, 32'hF0000010);
        mode_i = FIQ; #1;
        check("R10 cur sr in fiq", sr_cur_o, 32'hF0000010);

        // R1: reset again clears registers.
        @(negedge clk);
        rst_n = 1'b0; tick();
        rst_n = 1'b1; mode_i = USR; rd_a_idx = 4'd8; rd_b_idx = 4'd15; #1;
        check("R1 r8 cleared", rd_a_data, 32'h0);
        check("R1 pc cleared", rd_b_data, 32'h0);
        check("R1 cur sr restored", sr_cur_o, 32'h13);
        mode_i = SVC; #1;
        check("R1 saved cleared", sr_saved_o, 32'h0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                errors++; checks++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule